// File: doc/BRIEF.md
# Shared RAM Ownership Controller

This block manages a handful of local RAM regions that are shared by a host processor, a control coprocessor and a debug port. Each shared region carries a small mode register that says who currently owns it: the host alone, the coprocessor as instruction storage, or the coprocessor as data storage. Every clock, the controller looks at the three requesters, decides for each one whether its access is served, held off or refused, and steers the winner onto the region's RAM.

Two extra message regions always belong to both processors. They carry data only and refuse any instruction fetch. A typical use runs in three steps. The host fills a region with code or tables while it still owns the region. The host then hands the region to the coprocessor by writing its mode. After that, both sides talk through the message regions.

The address of every requester is split into two parts. The upper bits select the region: shared regions come first, starting at index 0, and the two message regions follow them. The lower bits select a 16-bit word inside the region. The coprocessor fetches 32 bits in one access. The word at the even address sits in the low half of the fetched value and the next word sits in the high half.

Top module: `shram_ctrl`

## Requirements
- R1: After reset, every shared region is in host mode (mode code 0) with both protect bits clear. In this state a coprocessor access to a shared region is refused. Reset does not clear RAM contents.
- R2: A configuration write sets one shared region's mode and protect bits from `cfg_mode` (0 host, 1 program, 2 data) and the two protect inputs. The new setting governs accesses from the clock after the write. A write with mode code 3 is ignored as a whole.
- R3: In program mode, a coprocessor fetch at an even word address returns {word at addr+1, word at addr} as 32 bits. A coprocessor data access to the region is refused, and so is any host access to it.
- R4: A coprocessor fetch at an odd word address is refused with an error and returns zero.
- R5: In program mode, a debug access is granted only in a cycle in which no coprocessor fetch is served on that region. Otherwise `dbg_wait` is high in that cycle.
- R6: In data mode, coprocessor reads and writes are served. When the host addresses the same region in the same cycle, the coprocessor wins and `hst_wait` is high. A coprocessor fetch to a data-mode region is refused.
- R7: While a shared region is not in program mode, a host fetch is refused if the region's fetch-protect bit is set, and a host write is refused if its write-protect bit is set. A refused write leaves memory unchanged.
- R8: Message regions serve data reads and writes from the host, the coprocessor and debug. Any fetch to them is refused, and the coprocessor wins over the host on a same-region conflict.
- R9: A refused access gives a one-cycle error pulse on its requester's error output in the cycle after the request. The matching read data is zero in that cycle.
- R10: Read data of a granted access appears on the clock after the grant. A granted write returns zero read data.
- R11: Debug has the lowest priority in every region and waits while the host or the coprocessor is served there. Any access to a region index beyond the message regions is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Shared region being configured |
| cfg_mode | input | 2 | New mode: 0 host, 1 program, 2 data |
| cfg_fprot | input | 1 | New host fetch-protect bit |
| cfg_wprot | input | 1 | New host write-protect bit |
| hst_req | input | 1 | Host access request |
| hst_fetch | input | 1 | Host access is an instruction fetch (a read) |
| hst_we | input | 1 | Host write (ignored when fetching) |
| hst_addr | input | AW | Host word address |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data, one clock after grant |
| hst_wait | output | 1 | Host access held off this cycle |
| hst_err | output | 1 | Host access refused (one clock late) |
| cop_req | input | 1 | Coprocessor access request |
| cop_fetch | input | 1 | Coprocessor 32-bit instruction fetch |
| cop_we | input | 1 | Coprocessor write (ignored when fetching) |
| cop_addr | input | AW | Coprocessor word address |
| cop_wdata | input | DW | Coprocessor write data |
| cop_rdata | output | 2*DW | Coprocessor fetch or zero-extended read data |
| cop_err | output | 1 | Coprocessor access refused (one clock late) |
| dbg_req | input | 1 | Debug access request |
| dbg_we | input | 1 | Debug write |
| dbg_addr | input | AW | Debug word address |
| dbg_wdata | input | DW | Debug write data |
| dbg_rdata | output | DW | Debug read data, one clock after grant |
| dbg_wait | output | 1 | Debug access held off this cycle |
| dbg_err | output | 1 | Debug access refused (one clock late) |

## Verification
A wrong mode register shows up on the clock after the faulty write. From then on, accesses to that region raise the wrong error or return data where zero was expected. A faulty arbitration decision shows at once on `hst_wait` or `dbg_wait` in the same cycle. It also shows one clock later, as data read from the wrong lane or region, or as a write that landed when it should have been refused. That write is found by the next read of the same word.

// File: rtl/shram_pkg.sv
package shram_pkg;

  // Region ownership modes; codes match the cfg_mode input.
  typedef enum logic [1:0] {
    MD_HOST = 2'd0,
    MD_PROG = 2'd1,
    MD_DATA = 2'd2,
    MD_MSG  = 2'd3   // internal only: message region
  } mode_e;

endpackage

// File: rtl/shram_cfg.sv
module shram_cfg
  import shram_pkg::*;
#(
  parameter int NBLK = 4,
  parameter int IW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_fprot,
  input  logic            cfg_wprot,
  output mode_e           mode_q [NBLK],
  output logic [NBLK-1:0] fp_q,
  output logic [NBLK-1:0] wp_q
);

  logic take;
  assign take = cfg_we && (32'(cfg_idx) < NBLK) && (cfg_mode != 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBLK; b++) mode_q[b] <= MD_HOST;
      fp_q <= '0;
      wp_q <= '0;
    end else if (take) begin
      mode_q[cfg_idx] <= mode_e'(cfg_mode);
      fp_q[cfg_idx]   <= cfg_fprot;
      wp_q[cfg_idx]   <= cfg_wprot;
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_chk
    AST_CFG_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mode_q[b] == MD_HOST && !fp_q[b] && !wp_q[b])); // R1
  end

endmodule

// File: rtl/shram_bank.sv
module shram_bank #(
  parameter int IAW = 5,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           en,
  input  logic           we_lo,
  input  logic           we_hi,
  input  logic [IAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd_lo,
  output logic [DW-1:0]  rd_hi
);

  localparam int DEPTH = 1 << IAW;

  // Even words in one array, odd words in the other, so a 32-bit fetch
  // reads both lanes in a single cycle.
  logic [DW-1:0] mem_lo [DEPTH];
  logic [DW-1:0] mem_hi [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we_lo) mem_lo[addr] <= wdata;
      rd_lo <= mem_lo[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (we_hi) mem_hi[addr] <= wdata;
      rd_hi <= mem_hi[addr];
    end
  end

endmodule

// File: rtl/shram_arb.sv
module shram_arb
  import shram_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int NREG  = NBLK + 2,
  parameter int RW    = $clog2(NREG),
  parameter int NSLOT = 1 << RW
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode_q [NBLK],
  input  logic [NBLK-1:0]  fp_q,
  input  logic [NBLK-1:0]  wp_q,
  input  logic             h_req,
  input  logic             h_fetch,
  input  logic             h_wr,
  input  logic [RW-1:0]    h_rg,
  input  logic             c_req,
  input  logic             c_fetch,
  input  logic             c_odd,
  input  logic [RW-1:0]    c_rg,
  input  logic             d_req,
  input  logic [RW-1:0]    d_rg,
  output logic             h_gnt,
  output logic             h_wait,
  output logic             h_err,
  output logic             c_gnt,
  output logic             c_err,
  output logic             d_gnt,
  output logic             d_wait,
  output logic             d_err,
  output logic [NSLOT-1:0] sel_h,
  output logic [NSLOT-1:0] sel_c,
  output logic [NSLOT-1:0] sel_d
);

  mode_e            smode [NSLOT];
  logic [NSLOT-1:0] svalid, sfp, swp;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < NBLK) begin : g_shared
      assign smode[s]  = mode_q[s];
      assign svalid[s] = 1'b1;
      assign sfp[s]    = fp_q[s];
      assign swp[s]    = wp_q[s];
    end else if (s < NREG) begin : g_msg
      assign smode[s]  = MD_MSG;
      assign svalid[s] = 1'b1;
      assign sfp[s]    = 1'b0;
      assign swp[s]    = 1'b0;
    end else begin : g_hole
      assign smode[s]  = MD_HOST;
      assign svalid[s] = 1'b0;
      assign sfp[s]    = 1'b0;
      assign swp[s]    = 1'b0;
    end
  end

  mode_e hm, cm;
  logic  c_ok, h_ok, d_ok, h_hit, d_busy;

  always_comb begin
    hm = smode[h_rg];
    cm = smode[c_rg];

    unique case (cm)
      MD_MSG:  c_ok = !c_fetch;
      MD_PROG: c_ok = c_fetch && !c_odd;
      MD_DATA: c_ok = !c_fetch;
      default: c_ok = 1'b0;
    endcase
    c_ok = c_ok && c_req && svalid[c_rg];

    unique case (hm)
      MD_MSG:  h_ok = !h_fetch;
      MD_PROG: h_ok = 1'b0;
      default: h_ok = !(h_fetch && sfp[h_rg]) && !(h_wr && swp[h_rg]);
    endcase
    h_ok = h_ok && h_req && svalid[h_rg];

    d_ok = d_req && svalid[d_rg];

    h_hit  = c_ok && (c_rg == h_rg);
    c_gnt  = c_ok;
    c_err  = c_req && !c_ok;
    h_gnt  = h_ok && !h_hit;
    h_wait = h_ok && h_hit;
    h_err  = h_req && !h_ok;

    d_busy = (c_ok && (c_rg == d_rg)) || (h_gnt && (h_rg == d_rg));
    d_gnt  = d_ok && !d_busy;
    d_wait = d_ok && d_busy;
    d_err  = d_req && !d_ok;

    sel_c = c_gnt ? (NSLOT'(1) << c_rg) : '0;
    sel_h = h_gnt ? (NSLOT'(1) << h_rg) : '0;
    sel_d = d_gnt ? (NSLOT'(1) << d_rg) : '0;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_excl
    AST_SLOT_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({sel_h[s], sel_c[s], sel_d[s]})); // R6
  end

  AST_DBG_GAP: assert property (@(posedge clk) disable iff (rst)
    (d_gnt && smode[d_rg] == MD_PROG) |-> !(c_req && c_fetch && !c_odd && c_rg == d_rg)); // R5

  AST_HOST_PROG_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (h_req && smode[h_rg] == MD_PROG) |-> h_err); // R3

  AST_MSG_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (c_req && c_fetch && smode[c_rg] == MD_MSG) |-> c_err); // R8

endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_pkg::*;
#(
  parameter int NBLK = 4,
  parameter int BW   = 6,
  parameter int DW   = 16,
  localparam int NREG  = NBLK + 2,
  localparam int RW    = $clog2(NREG),
  localparam int NSLOT = 1 << RW,
  localparam int AW    = RW + BW,
  localparam int IW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_fprot,
  input  logic          cfg_wprot,
  input  logic          hst_req,
  input  logic          hst_fetch,
  input  logic          hst_we,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          hst_wait,
  output logic          hst_err,
  input  logic          cop_req,
  input  logic          cop_fetch,
  input  logic          cop_we,
  input  logic [AW-1:0] cop_addr,
  input  logic [DW-1:0] cop_wdata,
  output logic [2*DW-1:0] cop_rdata,
  output logic          cop_err,
  input  logic          dbg_req,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata,
  output logic          dbg_wait,
  output logic          dbg_err
);

  mode_e            mode_q [NBLK];
  logic [NBLK-1:0]  fp_q, wp_q;

  shram_cfg #(.NBLK(NBLK), .IW(IW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_mode(cfg_mode), .cfg_fprot(cfg_fprot), .cfg_wprot(cfg_wprot),
    .mode_q(mode_q), .fp_q(fp_q), .wp_q(wp_q)
  );

  logic [RW-1:0] h_rg, c_rg, d_rg;
  logic          h_wr, c_wr;
  assign h_rg = hst_addr[AW-1:BW];
  assign c_rg = cop_addr[AW-1:BW];
  assign d_rg = dbg_addr[AW-1:BW];
  assign h_wr = hst_we && !hst_fetch;
  assign c_wr = cop_we && !cop_fetch;

  logic h_gnt, h_err_now, c_gnt, c_err_now, d_gnt, d_err_now;
  logic [NSLOT-1:0] sel_h, sel_c, sel_d;

  shram_arb #(.NBLK(NBLK), .NREG(NREG), .RW(RW), .NSLOT(NSLOT)) u_arb (
    .clk(clk), .rst(rst), .mode_q(mode_q), .fp_q(fp_q), .wp_q(wp_q),
    .h_req(hst_req), .h_fetch(hst_fetch), .h_wr(h_wr), .h_rg(h_rg),
    .c_req(cop_req), .c_fetch(cop_fetch), .c_odd(cop_addr[0]), .c_rg(c_rg),
    .d_req(dbg_req), .d_rg(d_rg),
    .h_gnt(h_gnt), .h_wait(hst_wait), .h_err(h_err_now),
    .c_gnt(c_gnt), .c_err(c_err_now),
    .d_gnt(d_gnt), .d_wait(dbg_wait), .d_err(d_err_now),
    .sel_h(sel_h), .sel_c(sel_c), .sel_d(sel_d)
  );

  logic [DW-1:0] lo [NSLOT];
  logic [DW-1:0] hi [NSLOT];

  for (genvar r = 0; r < NSLOT; r++) begin : g_reg
    if (r < NREG) begin : g_ram
      logic [BW-2:0] b_addr;
      logic [DW-1:0] b_wd;
      logic          b_lane, b_wr, b_en;

      always_comb begin
        if (sel_c[r]) begin
          b_addr = cop_addr[BW-1:1]; b_lane = cop_addr[0];
          b_wr   = c_wr;             b_wd   = cop_wdata;
        end else if (sel_h[r]) begin
          b_addr = hst_addr[BW-1:1]; b_lane = hst_addr[0];
          b_wr   = h_wr;             b_wd   = hst_wdata;
        end else begin
          b_addr = dbg_addr[BW-1:1]; b_lane = dbg_addr[0];
          b_wr   = dbg_we;           b_wd   = dbg_wdata;
        end
        b_en = sel_c[r] || sel_h[r] || sel_d[r];
      end

      shram_bank #(.IAW(BW-1), .DW(DW)) u_bank (
        .clk(clk), .en(b_en),
        .we_lo(b_en && b_wr && !b_lane), .we_hi(b_en && b_wr && b_lane),
        .addr(b_addr), .wdata(b_wd), .rd_lo(lo[r]), .rd_hi(hi[r])
      );
    end else begin : g_none
      assign lo[r] = '0;
      assign hi[r] = '0;
    end
  end

  // Per-requester return path, aligned with the RAM output register.
  logic          h_rd_q, h_lane_q, c_rd_q, c_lane_q, c_fetch_q, d_rd_q, d_lane_q;
  logic [RW-1:0] h_rg_q, c_rg_q, d_rg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rd_q <= 1'b0; c_rd_q <= 1'b0; d_rd_q <= 1'b0;
      h_lane_q <= 1'b0; c_lane_q <= 1'b0; d_lane_q <= 1'b0; c_fetch_q <= 1'b0;
      h_rg_q <= '0; c_rg_q <= '0; d_rg_q <= '0;
      hst_err <= 1'b0; cop_err <= 1'b0; dbg_err <= 1'b0;
    end else begin
      h_rd_q    <= h_gnt && !h_wr;
      c_rd_q    <= c_gnt && !c_wr;
      d_rd_q    <= d_gnt && !dbg_we;
      h_lane_q  <= hst_addr[0];
      c_lane_q  <= cop_addr[0];
      d_lane_q  <= dbg_addr[0];
      c_fetch_q <= cop_fetch;
      h_rg_q    <= h_rg;
      c_rg_q    <= c_rg;
      d_rg_q    <= d_rg;
      hst_err   <= h_err_now;
      cop_err   <= c_err_now;
      dbg_err   <= d_err_now;
    end
  end

  always_comb begin
    hst_rdata = '0;
    if (h_rd_q) hst_rdata = h_lane_q ? hi[h_rg_q] : lo[h_rg_q];
    dbg_rdata = '0;
    if (d_rd_q) dbg_rdata = d_lane_q ? hi[d_rg_q] : lo[d_rg_q];
    cop_rdata = '0;
    if (c_rd_q) begin
      if (c_fetch_q) cop_rdata = {hi[c_rg_q], lo[c_rg_q]};
      else           cop_rdata = {{DW{1'b0}}, (c_lane_q ? hi[c_rg_q] : lo[c_rg_q])};
    end
  end

  AST_ERR_ZERO_HST: assert property (@(posedge clk) disable iff (rst)
    hst_err |-> (hst_rdata == '0)); // R9
  AST_ERR_ZERO_COP: assert property (@(posedge clk) disable iff (rst)
    cop_err |-> (cop_rdata == '0)); // R9
  AST_ODD_FETCH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cop_req && cop_fetch && cop_addr[0])) |-> (cop_err && cop_rdata == '0)); // R4
  AST_WAIT_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    hst_wait |=> !hst_err); // R6

endmodule

// File: tb/sim_shram_ctrl.sv
module sim_shram_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 9;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS/2) clk = ~clk;

  logic          cfg_we = 0, cfg_fprot = 0, cfg_wprot = 0;
  logic [1:0]    cfg_idx = 0, cfg_mode = 0;
  logic          hst_req = 0, hst_fetch = 0, hst_we = 0;
  logic [AW-1:0] hst_addr = 0;
  logic [DW-1:0] hst_wdata = 0;
  logic          cop_req = 0, cop_fetch = 0, cop_we = 0;
  logic [AW-1:0] cop_addr = 0;
  logic [DW-1:0] cop_wdata = 0;
  logic          dbg_req = 0, dbg_we = 0;
  logic [AW-1:0] dbg_addr = 0;
  logic [DW-1:0] dbg_wdata = 0;
  logic [DW-1:0] hst_rdata, dbg_rdata;
  logic [2*DW-1:0] cop_rdata;
  logic          hst_wait, hst_err, cop_err, dbg_wait, dbg_err;

  shram_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
    .cfg_fprot(cfg_fprot), .cfg_wprot(cfg_wprot),
    .hst_req(hst_req), .hst_fetch(hst_fetch), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_wait(hst_wait), .hst_err(hst_err),
    .cop_req(cop_req), .cop_fetch(cop_fetch), .cop_we(cop_we), .cop_addr(cop_addr),
    .cop_wdata(cop_wdata), .cop_rdata(cop_rdata), .cop_err(cop_err),
    .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .dbg_wait(dbg_wait), .dbg_err(dbg_err)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        hr, hf, hw;  logic [8:0] ha; logic [15:0] hd;
    logic        cr, cf, cw;  logic [8:0] ca; logic [15:0] cd;
    logic        dr;          logic [8:0] da;
    logic        ehw, edw, ehe, ece, ede;
    logic [15:0] ehd; logic [31:0] ecd; logic [15:0] edd;
  } vec_t;

  // Region map: 0..3 shared, 4..5 message, 6..7 unused; 6 word bits per region.
  // Setup leaves region 0 host, 1 program, 2 data, 3 host with both protect bits.
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd10, 1'b1,1'b0,1'b1,9'h003,16'hA5A5, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0000,32'h0,16'h0000}, // R10 write
    '{4'd11, 1'b1,1'b0,1'b0,9'h003,16'h0000, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b1,9'h003, 1'b0,1'b1,1'b0,1'b0,1'b0, 16'hA5A5,32'h0,16'h0000}, // R11 debug behind host
    '{4'd5,  1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b1,1'b1,1'b0,9'h040,16'h0000, 1'b1,9'h041, 1'b0,1'b1,1'b0,1'b0,1'b0, 16'h0000,32'h2222_1111,16'h0000}, // R5 R3
    '{4'd5,  1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b1,9'h041, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0000,32'h0,16'h2222}, // R5 gap
    '{4'd4,  1'b1,1'b0,1'b0,9'h040,16'h0000, 1'b1,1'b1,1'b0,9'h041,16'h0000, 1'b1,9'h040, 1'b0,1'b0,1'b1,1'b1,1'b0, 16'h0000,32'h0,16'h1111}, // R4 R3
    '{4'd6,  1'b1,1'b0,1'b0,9'h084,16'h0000, 1'b1,1'b0,1'b1,9'h084,16'h0BEE, 1'b0,9'h000, 1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0000,32'h0,16'h0000}, // R6 R2
    '{4'd6,  1'b1,1'b0,1'b0,9'h084,16'h0000, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0BEE,32'h0,16'h0000}, // R6
    '{4'd6,  1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b1,1'b1,1'b0,9'h084,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b0,1'b1,1'b0, 16'h0000,32'h0,16'h0000}, // R6 fetch refused
    '{4'd7,  1'b1,1'b0,1'b1,9'h0C0,16'h9999, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0000,32'h0,16'h0000}, // R7 write protect
    '{4'd7,  1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b1,9'h0C0, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0000,32'h0,16'h3333}, // R7 unchanged
    '{4'd7,  1'b1,1'b1,1'b0,9'h0C0,16'h0000, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0000,32'h0,16'h0000}, // R7 fetch protect
    '{4'd7,  1'b1,1'b1,1'b0,9'h003,16'h0000, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'hA5A5,32'h0,16'h0000}, // R7 unprotected
    '{4'd8,  1'b1,1'b1,1'b0,9'h142,16'h0000, 1'b1,1'b0,1'b1,9'h101,16'h4444, 1'b0,9'h000, 1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0000,32'h0,16'h0000}, // R8
    '{4'd8,  1'b1,1'b0,1'b0,9'h101,16'h0000, 1'b1,1'b0,1'b0,9'h101,16'h0000, 1'b0,9'h000, 1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0000,32'h0000_4444,16'h0000}, // R8
    '{4'd8,  1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b1,1'b1,1'b0,9'h142,16'h0000, 1'b1,9'h180, 1'b0,1'b0,1'b0,1'b1,1'b1, 16'h0000,32'h0,16'h0000}, // R8 R11
    '{4'd3,  1'b1,1'b0,1'b0,9'h003,16'h0000, 1'b1,1'b0,1'b0,9'h040,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b0,1'b1,1'b0, 16'hA5A5,32'h0,16'h0000}, // R3 data refused
    '{4'd9,  1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b1,1'b0,1'b1,9'h003,16'h7777, 1'b0,9'h000, 1'b0,1'b0,1'b0,1'b1,1'b0, 16'h0000,32'h0,16'h0000}, // R9
    '{4'd9,  1'b1,1'b0,1'b0,9'h003,16'h0000, 1'b0,1'b0,1'b0,9'h000,16'h0000, 1'b0,9'h000, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'hA5A5,32'h0,16'h0000}  // R9 unchanged
  };

  int checks = 0;
  int errs = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; hst_req = 0; hst_fetch = 0; hst_we = 0;
    cop_req = 0; cop_fetch = 0; cop_we = 0; dbg_req = 0; dbg_we = 0;
  endtask

  task automatic hst(input logic f, input logic w, input logic [8:0] a, input logic [15:0] d);
    hst_req = 1; hst_fetch = f; hst_we = w; hst_addr = a; hst_wdata = d;
  endtask

  task automatic cfg(input logic [1:0] i, input logic [1:0] m, input logic fp, input logic wp);
    cfg_we = 1; cfg_idx = i; cfg_mode = m; cfg_fprot = fp; cfg_wprot = wp;
  endtask

  initial begin
    #(CLK_NS * 20000);
    errs++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset hst_err", {31'b0, hst_err}, 0);
    chk("R1 reset cop_rdata", cop_rdata, 0);
    chk("R1 reset dbg_err", {31'b0, dbg_err}, 0);

    // Coprocessor data read to host-owned region; host preloads region 1.
    cop_req = 1; cop_addr = 9'h003; hst(0, 1, 9'h040, 16'h1111);
    tick(); idle();
    chk("R1 cop refused in host mode", {31'b0, cop_err}, 1);
    chk("R1 host write no error", {31'b0, hst_err}, 0);
    hst(0, 1, 9'h041, 16'h2222); tick(); idle();
    hst(0, 1, 9'h0C0, 16'h3333); tick(); idle();

    // Mode write and access in the same cycle: old mode still applies.
    cfg(2'd1, 2'd1, 0, 0); hst(0, 0, 9'h040, 0);
    tick(); idle();
    chk("R2 old mode rdata", {16'b0, hst_rdata}, 32'h1111);
    chk("R2 old mode err", {31'b0, hst_err}, 0);
    cfg(2'd2, 2'd2, 0, 0); hst(0, 0, 9'h040, 0);
    tick(); idle();
    chk("R2 new mode err", {31'b0, hst_err}, 1);
    chk("R9 refused read zero", {16'b0, hst_rdata}, 0);
    cfg(2'd3, 2'd0, 1, 1); tick(); idle();
    cfg(2'd2, 2'd3, 1, 1); tick(); idle();   // R2 reserved code ignored
    tick();

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      hst_req = v.hr; hst_fetch = v.hf; hst_we = v.hw; hst_addr = v.ha; hst_wdata = v.hd;
      cop_req = v.cr; cop_fetch = v.cf; cop_we = v.cw; cop_addr = v.ca; cop_wdata = v.cd;
      dbg_req = v.dr; dbg_we = 0; dbg_addr = v.da;
      #1;
      chk($sformatf("R%0d vec%0d hst_wait", v.rq, i), {31'b0, hst_wait}, {31'b0, v.ehw});
      chk($sformatf("R%0d vec%0d dbg_wait", v.rq, i), {31'b0, dbg_wait}, {31'b0, v.edw});
      tick(); idle();
      chk($sformatf("R%0d vec%0d hst_err", v.rq, i), {31'b0, hst_err}, {31'b0, v.ehe});
      chk($sformatf("R%0d vec%0d cop_err", v.rq, i), {31'b0, cop_err}, {31'b0, v.ece});
      chk($sformatf("R%0d vec%0d dbg_err", v.rq, i), {31'b0, dbg_err}, {31'b0, v.ede});
      chk($sformatf("R%0d vec%0d hst_rdata", v.rq, i), {16'b0, hst_rdata}, {16'b0, v.ehd});
      chk($sformatf("R%0d vec%0d cop_rdata", v.rq, i), cop_rdata, v.ecd);
      chk($sformatf("R%0d vec%0d dbg_rdata", v.rq, i), {16'b0, dbg_rdata}, {16'b0, v.edd});
    end

    // Error pulse lasts one cycle only.
    tick();
    chk("R9 error pulse cleared", {31'b0, cop_err}, 0);

    // Second reset: ownership returns to the host, RAM content survives.
    rst = 1; tick(); tick(); rst = 0;
    cop_req = 1; cop_fetch = 1; cop_addr = 9'h040; hst(0, 0, 9'h040, 0);
    tick(); idle();
    chk("R1 fetch refused after reset", {31'b0, cop_err}, 1);
    chk("R1 memory kept", {16'b0, hst_rdata}, 32'h1111);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule